// File: doc/BRIEF.md
# Protection Fault Supervisor

This block is the supervisory state machine of a primary-side LED driver controller. It decides whether the power switch may be driven. It watches a set of comparator flags: the supply against its turn-on, turn-off and reset levels, supply over-voltage, brown-out, over-temperature, current-sense pin short, winding/diode short and the auxiliary-winding level against its short threshold. From these flags it chooses how the controller stops and how it comes back.

Faults fall into three recovery groups. The first group forces a restart through a supply hiccup: the machine waits for the supply to drain to the turn-off level and then restarts. The second group waits on a long recovery timer and restarts only when the supply is again above turn-on. The third group latches until the supply collapses below the reset level. A build-time option chooses whether the two short-circuit faults latch or auto-recover. Every restart goes through a soft-start dwell before switching resumes. All durations are parameters counted in clock cycles.

Top module: `fault_supervisor`

## Requirements
- R1: After synchronous reset, `state` is 0 (startup), `startup_cur` is 1, and `drv_en` and `low_power` are 0.
- R2: From startup (0), the machine moves to the soft-start state (1) on the next clock when `vcc_above_on` is 1, `bo_low` is 0 and `vcc_below_rst` is 0. While `bo_low` is 1 it stays in startup. It stays in soft-start for exactly SOFTSTART_CYC clocks after entry and then enters run (2). `drv_en` is high only in run.
- R3: In run, `drv_en` falls in the same cycle that any of `vcc_below_off`, `vcc_below_rst`, `vcc_ovp`, `bo_low`, `temp_hot`, `cs_short`, `wind_short` or the internal auxiliary short fault goes high.
- R4: `vcc_below_off`, `bo_low`, `temp_hot` or `cs_short` in soft-start or run moves the machine to drain (3). Drain goes to startup when `vcc_below_off` is 1. Clearing `temp_hot` or `cs_short` has no effect on drain.
- R5: While the machine is in drain, a falling edge of `bo_low` takes it to startup on the next clock, whatever the level of `vcc_below_off`.
- R6: `vcc_ovp` moves the machine to recovery (4). Recovery moves to soft-start on the first clock after RECOVER_CYC clocks in recovery at which `vcc_above_on` is 1. Before that, and while `vcc_above_on` is 0, it stays in recovery.
- R7: With LATCHED=0, a winding/diode short or an auxiliary short moves the machine to recovery (4).
- R8: With LATCHED=1, those two short faults move the machine to latch (5). Only `vcc_below_rst` releases latch; the other inputs have no effect on it.
- R9: While in run, `zcd_low` held high for ZCD_SHORT_CYC consecutive clocks raises the auxiliary short fault. A single clock with `zcd_low` low restarts the count.
- R10: When several faults appear together, the reset level wins, then the short faults, then the hiccup group, then over-voltage.
- R11: `vcc_below_rst` in any state moves the machine to startup (0) on the next clock.
- R12: `low_power` is 1 exactly in drain, recovery and latch. `startup_cur` is 1 exactly in startup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_above_on | input | 1 | Supply is at or above the turn-on level |
| vcc_below_off | input | 1 | Supply is below the turn-off level |
| vcc_below_rst | input | 1 | Supply is below the logic reset level |
| vcc_ovp | input | 1 | Supply over-voltage (open load) |
| bo_low | input | 1 | Line brown-out is active |
| temp_hot | input | 1 | Over-temperature |
| cs_short | input | 1 | Current-sense pin short detected |
| wind_short | input | 1 | Winding or output diode short detected |
| zcd_low | input | 1 | Auxiliary-winding level is below its short threshold |
| drv_en | output | 1 | Gate-drive enable |
| low_power | output | 1 | Low-consumption mode |
| startup_cur | output | 1 | Draw startup current |
| state | output | 3 | Current state: 0 startup, 1 soft-start, 2 run, 3 drain, 4 recovery, 5 latch |

## Verification
The bench targets the edges of each timer. It checks the exact clock on which soft-start hands over to run and recovery hands over to soft-start; a counter off by one would switch a clock early or late. It holds the auxiliary level low one clock short of the limit, then breaks the run with a single high clock and holds it again. A counter that did not clear would raise a short fault that should not occur. It runs two instances with the latched and auto-recovery options side by side under random mixtures of faults to check priority. A wrong order would send a mixed fault into drain instead of latch. Directed cases cover the brown-out release path out of drain and show that latch ignores the turn-off, brown-out and turn-on flags.

// File: rtl/psup_pkg.sv
package psup_pkg;

  typedef enum logic [2:0] {
    PS_RESET   = 3'd0,
    PS_STOP    = 3'd1,
    PS_RUN     = 3'd2,
    PS_DRAIN   = 3'd3,
    PS_RECOVER = 3'd4,
    PS_LATCH   = 3'd5
  } psup_state_e;

  typedef struct packed {
    logic rst_low;    // supply under the logic reset level
    logic short_any;  // winding/diode or auxiliary short
    logic hiccup;     // faults restarted through a supply hiccup
    logic ovp;        // supply over-voltage
  } psup_fault_s;

  function automatic psup_state_e short_dest(input bit latched);
    return latched ? PS_LATCH : PS_RECOVER;
  endfunction

endpackage

// File: rtl/psup_dwell_timer.sv
module psup_dwell_timer #(
  parameter int unsigned LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q != LIM) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == LIM);

  AST_TMR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    !run |=> (cnt_q == '0)); // R9

  AST_TMR_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && cnt_q != LIM) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R9

endmodule

// File: rtl/psup_fault_map.sv
module psup_fault_map
  import psup_pkg::*;
(
  input  logic        vcc_below_off,
  input  logic        vcc_below_rst,
  input  logic        vcc_ovp,
  input  logic        bo_low,
  input  logic        temp_hot,
  input  logic        cs_short,
  input  logic        wind_short,
  input  logic        aux_short,
  output psup_fault_s flt,
  output logic        any_fault
);
  always_comb begin
    flt.rst_low   = vcc_below_rst;
    flt.short_any = wind_short | aux_short;
    flt.hiccup    = vcc_below_off | bo_low | temp_hot | cs_short;
    flt.ovp       = vcc_ovp;
    any_fault     = flt.rst_low | flt.short_any | flt.hiccup | flt.ovp;
  end
endmodule

// File: rtl/psup_core.sv
module psup_core
  import psup_pkg::*;
#(
  parameter bit LATCHED = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  psup_fault_s flt,
  input  logic        any_fault,
  input  logic        vcc_above_on,
  input  logic        vcc_below_off,
  input  logic        bo_low,
  input  logic        ss_done,
  input  logic        rec_done,
  output psup_state_e state_q,
  output logic        drv_en,
  output logic        low_power,
  output logic        startup_cur
);
  psup_state_e nxt;
  logic        run_q;
  logic        bo_q;
  logic        bo_release;

  assign bo_release = bo_q & ~bo_low;

  always_comb begin
    nxt = state_q;
    unique case (state_q)
      PS_RESET: begin
        if (!flt.rst_low && vcc_above_on && !bo_low) nxt = PS_STOP;
      end
      PS_STOP, PS_RUN: begin
        if (flt.rst_low)                       nxt = PS_RESET;
        else if (flt.short_any)                nxt = short_dest(LATCHED);
        else if (flt.hiccup)                   nxt = PS_DRAIN;
        else if (flt.ovp)                      nxt = PS_RECOVER;
        else if (state_q == PS_STOP && ss_done) nxt = PS_RUN;
      end
      PS_DRAIN: begin
        if (flt.rst_low || vcc_below_off || bo_release) nxt = PS_RESET;
      end
      PS_RECOVER: begin
        if (flt.rst_low)                   nxt = PS_RESET;
        else if (rec_done && vcc_above_on) nxt = PS_STOP;
      end
      PS_LATCH: begin
        if (flt.rst_low) nxt = PS_RESET;
      end
      default: nxt = PS_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= PS_RESET;
      run_q       <= 1'b0;
      low_power   <= 1'b0;
      startup_cur <= 1'b1;
      bo_q        <= 1'b0;
    end else begin
      state_q     <= nxt;
      run_q       <= (nxt == PS_RUN);
      low_power   <= (nxt == PS_DRAIN) || (nxt == PS_RECOVER) || (nxt == PS_LATCH);
      startup_cur <= (nxt == PS_RESET);
      bo_q        <= bo_low;
    end
  end

  // Registered run flag gated combinationally so a fault cuts drive at once.
  assign drv_en = run_q & ~any_fault;

  AST_DRV_IN_RUN: assert property (@(posedge clk) disable iff (rst)
    drv_en |-> (state_q == PS_RUN)); // R2

  AST_FAULT_LEAVES_RUN: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_RUN && any_fault) |=> (state_q != PS_RUN)); // R3

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_LATCH && !flt.rst_low) |=> (state_q == PS_LATCH)); // R8

  AST_RECOVER_GATED: assert property (@(posedge clk) disable iff (rst)
    (state_q == PS_RECOVER && !(rec_done && vcc_above_on) && !flt.rst_low)
      |=> (state_q == PS_RECOVER)); // R6

  AST_RST_LOW_WINS: assert property (@(posedge clk) disable iff (rst)
    flt.rst_low |=> (state_q == PS_RESET)); // R11

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(startup_cur && low_power)); // R12

endmodule

// File: rtl/fault_supervisor.sv
module fault_supervisor
  import psup_pkg::*;
#(
  parameter int unsigned ZCD_SHORT_CYC = 9_000_000,
  parameter int unsigned RECOVER_CYC   = 400_000_000,
  parameter int unsigned SOFTSTART_CYC = 4_000,
  parameter bit          LATCHED       = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_above_on,
  input  logic       vcc_below_off,
  input  logic       vcc_below_rst,
  input  logic       vcc_ovp,
  input  logic       bo_low,
  input  logic       temp_hot,
  input  logic       cs_short,
  input  logic       wind_short,
  input  logic       zcd_low,
  output logic       drv_en,
  output logic       low_power,
  output logic       startup_cur,
  output logic [2:0] state
);
  psup_state_e st_q;
  psup_fault_s flt;
  logic        any_fault;
  logic        aux_short;
  logic        ss_done;
  logic        rec_done;

  psup_dwell_timer #(.LIMIT(ZCD_SHORT_CYC)) u_zcd_watch (
    .clk  (clk),
    .rst  (rst),
    .run  ((st_q == PS_RUN) && zcd_low),
    .done (aux_short)
  );

  psup_dwell_timer #(.LIMIT(SOFTSTART_CYC)) u_softstart (
    .clk  (clk),
    .rst  (rst),
    .run  (st_q == PS_STOP),
    .done (ss_done)
  );

  psup_dwell_timer #(.LIMIT(RECOVER_CYC)) u_recover (
    .clk  (clk),
    .rst  (rst),
    .run  (st_q == PS_RECOVER),
    .done (rec_done)
  );

  psup_fault_map u_map (
    .vcc_below_off (vcc_below_off),
    .vcc_below_rst (vcc_below_rst),
    .vcc_ovp       (vcc_ovp),
    .bo_low        (bo_low),
    .temp_hot      (temp_hot),
    .cs_short      (cs_short),
    .wind_short    (wind_short),
    .aux_short     (aux_short),
    .flt           (flt),
    .any_fault     (any_fault)
  );

  psup_core #(.LATCHED(LATCHED)) u_core (
    .clk           (clk),
    .rst           (rst),
    .flt           (flt),
    .any_fault     (any_fault),
    .vcc_above_on  (vcc_above_on),
    .vcc_below_off (vcc_below_off),
    .bo_low        (bo_low),
    .ss_done       (ss_done),
    .rec_done      (rec_done),
    .state_q       (st_q),
    .drv_en        (drv_en),
    .low_power     (low_power),
    .startup_cur   (startup_cur)
  );

  assign state = st_q;

endmodule

// File: tb/fault_supervisor_tb_top.sv
`timescale 1ns/1ps
module fault_supervisor_tb_top;
  localparam int ZN = 20;
  localparam int RC = 30;
  localparam int SS = 8;
  localparam int S_RESET = 0, S_STOP = 1, S_RUN = 2, S_DRAIN = 3, S_REC = 4, S_LATCH = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vcc_on = 0, off_low = 0, rst_low = 0, ovp = 0, bo = 0, hot = 0, css = 0, wnd = 0, zcd = 0;
  logic drv_a, lp_a, su_a, drv_b, lp_b, su_b;
  logic [2:0] st_a, st_b;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  fault_supervisor #(.ZCD_SHORT_CYC(ZN), .RECOVER_CYC(RC), .SOFTSTART_CYC(SS), .LATCHED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .vcc_above_on(vcc_on), .vcc_below_off(off_low), .vcc_below_rst(rst_low),
    .vcc_ovp(ovp), .bo_low(bo), .temp_hot(hot), .cs_short(css), .wind_short(wnd), .zcd_low(zcd),
    .drv_en(drv_a), .low_power(lp_a), .startup_cur(su_a), .state(st_a));

  fault_supervisor #(.ZCD_SHORT_CYC(ZN), .RECOVER_CYC(RC), .SOFTSTART_CYC(SS), .LATCHED(1'b0)) dut_ar (
    .clk(clk), .rst(rst), .vcc_above_on(vcc_on), .vcc_below_off(off_low), .vcc_below_rst(rst_low),
    .vcc_ovp(ovp), .bo_low(bo), .temp_hot(hot), .cs_short(css), .wind_short(wnd), .zcd_low(zcd),
    .drv_en(drv_b), .low_power(lp_b), .startup_cur(su_b), .state(st_b));

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_faults();
    off_low = 0; rst_low = 0; ovp = 0; bo = 0; hot = 0; css = 0; wnd = 0; zcd = 0;
  endtask

  // mask bits: 0 below-off, 1 brown-out, 2 hot, 3 cs short, 4 ovp, 5 winding short
  function automatic int exp_dest(input int mask, input bit latched);
    if (mask[5]) return latched ? S_LATCH : S_REC;
    if (mask[3:0] != 0) return S_DRAIN;
    if (mask[4]) return S_REC;
    return S_RUN;
  endfunction

  task automatic bring_up();
    clear_faults();
    rst_low = 1; off_low = 1;
    tick(2);
    rst_low = 0; off_low = 0; vcc_on = 1;
    tick(SS + 4);
    chk("R2 up a", st_a, S_RUN);
    chk("R2 up b", st_b, S_RUN);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    rst = 0;
    #0.5;
    chk("R1 state", st_a, S_RESET);
    chk("R1 startup_cur", su_a, 1);
    chk("R1 drv_en", drv_a, 0);
    chk("R1 low_power", lp_a, 0);

    // R2: brown-out holds startup, then exact soft-start length
    bo = 1; vcc_on = 1;
    tick(4);
    chk("R2 bo holds", st_a, S_RESET);
    bo = 0;
    tick(1);
    chk("R2 to stop", st_a, S_STOP);
    chk("R12 stop flags", su_a + lp_a, 0);
    tick(SS);
    chk("R2 ss not done", st_a, S_STOP);
    chk("R2 no drive in stop", drv_a, 0);
    tick(1);
    chk("R2 run", st_a, S_RUN);
    chk("R2 drive", drv_a, 1);

    // R6: exact recovery length
    ovp = 1;
    #1;
    chk("R3 drop same cycle", drv_a, 0);
    tick(1);
    chk("R6 recover", st_a, S_REC);
    chk("R12 lp recover", lp_a, 1);
    ovp = 0;
    tick(RC - 1);
    chk("R6 early", st_a, S_REC);
    tick(1);
    chk("R6 at limit", st_a, S_REC);
    tick(1);
    chk("R6 to stop", st_a, S_STOP);

    // R6: waits for turn-on level
    bring_up();
    ovp = 1; tick(1); ovp = 0; vcc_on = 0;
    tick(RC + 5);
    chk("R6 waits vcc_on", st_a, S_REC);
    vcc_on = 1;
    tick(1);
    chk("R6 vcc_on exit", st_a, S_STOP);

    // R5: brown-out release leaves drain at once
    bring_up();
    bo = 1; tick(1);
    chk("R4 bo drain", st_a, S_DRAIN);
    bo = 0; tick(1);
    chk("R5 bo release", st_a, S_RESET);
    chk("R12 startup_cur", su_a, 1);

    // R4: other faults clearing do not release drain
    bring_up();
    hot = 1; tick(1);
    chk("R4 hot drain", st_a, S_DRAIN);
    hot = 0; tick(4);
    chk("R4 drain holds", st_a, S_DRAIN);
    off_low = 1; tick(1);
    chk("R4 drain exit", st_a, S_RESET);

    // R9: auxiliary short timer and variants
    bring_up();
    zcd = 1;
    tick(ZN - 1);
    chk("R9 before limit", drv_a, 1);
    tick(1);
    chk("R9 at limit drv", drv_a, 0);
    chk("R9 at limit state", st_a, S_RUN);
    tick(1);
    chk("R8 latch", st_a, S_LATCH);
    chk("R7 autorecover", st_b, S_REC);
    zcd = 0;
    tick(RC + 2);
    chk("R7 b back to stop", st_b, S_STOP);
    chk("R8 a held", st_a, S_LATCH);
    off_low = 1; bo = 1; vcc_on = 0;
    tick(5);
    chk("R8 ignores others", st_a, S_LATCH);
    chk("R12 lp latch", lp_a, 1);
    off_low = 0; bo = 0; vcc_on = 1;
    tick(2);
    chk("R8 still latched", st_a, S_LATCH);
    rst_low = 1; tick(1);
    chk("R8 release", st_a, S_RESET);
    chk("R11 b reset", st_b, S_RESET);
    rst_low = 0;

    // R9: one high cycle clears the count
    bring_up();
    zcd = 1; tick(ZN - 1);
    zcd = 0; tick(1);
    zcd = 1; tick(ZN - 1);
    chk("R9 cleared a", st_a, S_RUN);
    chk("R9 cleared drv", drv_a, 1);
    zcd = 0; tick(1);

    // R10/R11: reset level beats a short
    bring_up();
    rst_low = 1; wnd = 1; tick(1);
    chk("R10 rst over short", st_a, S_RESET);
    chk("R11 rst in run", st_b, S_RESET);

    // Random fault mixtures
    for (int it = 0; it < 24; it++) begin
      int mask;
      bring_up();
      mask = $urandom_range(1, 63);
      off_low = mask[0]; bo = mask[1]; hot = mask[2]; css = mask[3]; ovp = mask[4]; wnd = mask[5];
      #1;
      chk("R3 rand drv a", drv_a, 0);
      chk("R3 rand drv b", drv_b, 0);
      tick(1);
      chk("R10 rand a", st_a, exp_dest(mask, 1'b1));
      chk("R10 rand b", st_b, exp_dest(mask, 1'b0));
      chk("R12 rand lp", lp_a, 1);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule